// File: doc/BRIEF.md
# Four-Rail Power Sequencing Controller

This block brings up three downstream supplies one after another and then raises a system power-good flag. It watches four digital rail-status inputs, each high when its rail sits above its undervoltage point. Rail 0 is the main supply. Rails 1, 2 and 3 are the outputs of the supplies that enables 0, 1 and 2 switch on. Each input first passes through a two-flop synchronizer. Every state transition is then qualified by a hold-time counter: a long hold for the first enable and for power-good, and a short deglitch hold for the other steps and for faults.

Once power-good is up, the controller guards the system. If any downstream rail stays low, power-good drops and the enables stay on. If the main rail stays low, everything shuts off and the sequence starts again from the off state. All hold times are computed from a clock-cycles-per-microsecond parameter, so a small configuration can run every delay in a short simulation.

Top module: `pwrseq_ctrl`

## Requirements
- R1: While `rst` is high, and while the controller is in the off state, `en_out` is 3'b000 and `pwr_good` is 0.
- R2: The outputs, written as {en_out[0], en_out[1], en_out[2], pwr_good}, take only the values 0000 (off), 1000, 1100, 1110 and 1111 (power-good). An enable is never high unless every lower-numbered enable is high.
- R3: From off, the controller moves to 1000 once rail_ok[0] has been continuously high for LONG_US·CLK_PER_US synchronized cycles. The output changes exactly LONG+2 clock edges after the input rises.
- R4: From 1000, the controller moves to 1100 once rail_ok[0] and rail_ok[1] have both been high for SHORT_US·CLK_PER_US cycles, which is SHORT+2 edges after the later of the two rises.
- R5: From 1100, the controller moves to 1110 once rail_ok[0] and rail_ok[2] have both been high for the short hold.
- R6: From 1110, the controller moves to 1111 only after all four rail_ok bits have been high together for the long hold.
- R7: In 1111, if any of rail_ok[3:1] has been low for the short hold, pwr_good falls and the outputs become 1110.
- R8: In any state other than off, rail_ok[0] low for the short hold sends the outputs to 0000 in a single cycle.
- R9: A condition that breaks before its hold completes restarts its count from zero. A low or high glitch shorter than the hold therefore changes no output.
- R10: Every state change reloads every hold counter. A return from 1110 to 1111 therefore needs a fresh full long hold, and a step whose inputs are already high takes exactly one hold after entry.
- R11: The long and short hold lengths in clock cycles are CLK_PER_US·LONG_US and CLK_PER_US·SHORT_US.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rail_ok | input | 4 | Asynchronous rail-above-threshold flags; bit 0 is the main rail |
| en_out | output | 3 | Supply enables; bit 0 is switched on first |
| pwr_good | output | 1 | System power-good flag |

## Verification
The assertions check on every cycle the following properties. The enable chain never has a gap. Power-good is never high without all three enables. A falling first enable takes everything down in the same cycle. A falling power-good with the main rail still up leaves all enables on. Inside each qualifier, a non-zero count implies that its condition held one cycle earlier. The exact hold lengths, including the two synchronizer cycles, cannot be expressed as properties here: the glitch restarts, the fresh long hold after a downstream fault and the immediate short step on already-high rails are shown only by the bench's timed scenarios, which compare each output change against edge counts derived from the parameters.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic [2:0] {
        ST_OFF    = 3'd0,
        ST_EN1    = 3'd1,
        ST_EN12   = 3'd2,
        ST_EN123  = 3'd3,
        ST_PGOOD  = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic [2:0] en;
        logic       pg;
    } seq_out_t;

    // Output image of each sequencing state.
    function automatic seq_out_t state_outputs(seq_state_e s);
        seq_out_t o;
        o = '0;
        unique case (s)
            ST_OFF:   o = '{en: 3'b000, pg: 1'b0};
            ST_EN1:   o = '{en: 3'b001, pg: 1'b0};
            ST_EN12:  o = '{en: 3'b011, pg: 1'b0};
            ST_EN123: o = '{en: 3'b111, pg: 1'b0};
            ST_PGOOD: o = '{en: 3'b111, pg: 1'b1};
            default:  o = '0;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/rail_sync.sv
module rail_sync #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic meta_q, sync_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
            end else begin
                meta_q <= din[i];
                sync_q <= meta_q;
            end
        end
        assign dout[i] = sync_q;
    end
endmodule

// File: rtl/hold_qual.sv
module hold_qual #(
    parameter int unsigned LIMIT = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic cond,
    input  logic restart,
    output logic done
);
    localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || restart || !cond)
            cnt_q <= '0;
        else if (cnt_q != LAST)
            cnt_q <= cnt_q + 1'b1;
    end

    // done fires on the LIMIT-th consecutive cycle with cond true
    assign done = cond && (cnt_q == LAST);

    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

    // a running count means the condition held on the previous edge
    p_count_needs_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != '0) |-> $past(cond));
endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
    import pwrseq_pkg::*;
#(
    parameter int unsigned CLK_PER_US = 100,
    parameter int unsigned LONG_US    = 190000,
    parameter int unsigned SHORT_US   = 30
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] rail_ok,
    output logic [2:0] en_out,
    output logic       pwr_good
);
    localparam int unsigned LONG_CYC  = CLK_PER_US * LONG_US;   // R11
    localparam int unsigned SHORT_CYC = CLK_PER_US * SHORT_US;  // R11

    logic [3:0] ok_s;
    seq_state_e state_q, state_d;
    logic       chg;
    logic       long_cond, short_cond, main_cond, rail_cond;
    logic       long_done, short_done, main_done, rail_done;
    seq_out_t   outs;

    rail_sync #(.N(4)) u_sync (
        .clk (clk), .rst (rst), .din (rail_ok), .dout (ok_s)
    );

    // qualifier conditions per state
    always_comb begin
        long_cond  = ((state_q == ST_OFF) && ok_s[0]) ||
                     ((state_q == ST_EN123) && (&ok_s));
        short_cond = ((state_q == ST_EN1)  && ok_s[0] && ok_s[1]) ||
                     ((state_q == ST_EN12) && ok_s[0] && ok_s[2]);
        main_cond  = (state_q != ST_OFF) && !ok_s[0];
        rail_cond  = (state_q == ST_PGOOD) && !(&ok_s[3:1]);
    end

    hold_qual #(.LIMIT(LONG_CYC)) u_q_long (
        .clk (clk), .rst (rst), .cond (long_cond), .restart (chg), .done (long_done)
    );
    hold_qual #(.LIMIT(SHORT_CYC)) u_q_step (
        .clk (clk), .rst (rst), .cond (short_cond), .restart (chg), .done (short_done)
    );
    hold_qual #(.LIMIT(SHORT_CYC)) u_q_main (
        .clk (clk), .rst (rst), .cond (main_cond), .restart (chg), .done (main_done)
    );
    hold_qual #(.LIMIT(SHORT_CYC)) u_q_rail (
        .clk (clk), .rst (rst), .cond (rail_cond), .restart (chg), .done (rail_done)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   if (long_done)  state_d = ST_EN1;
            ST_EN1:   if (main_done)  state_d = ST_OFF;
                      else if (short_done) state_d = ST_EN12;
            ST_EN12:  if (main_done)  state_d = ST_OFF;
                      else if (short_done) state_d = ST_EN123;
            ST_EN123: if (main_done)  state_d = ST_OFF;
                      else if (long_done)  state_d = ST_PGOOD;
            ST_PGOOD: if (main_done)  state_d = ST_OFF;
                      else if (rail_done)  state_d = ST_EN123;
            default:  state_d = ST_OFF;
        endcase
    end

    assign chg = (state_d != state_q);  // reload every counter (R10)

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_OFF;
        else     state_q <= state_d;
    end

    assign outs     = state_outputs(state_q);
    assign en_out   = outs.en;
    assign pwr_good = outs.pg;

    p_en_chain_r2: assert property (@(posedge clk) disable iff (rst)
        (en_out[2] |-> en_out[1]) and (en_out[1] |-> en_out[0]));

    p_pg_needs_all_r2: assert property (@(posedge clk) disable iff (rst)
        pwr_good |-> (en_out == 3'b111));

    p_first_en_from_off_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(en_out[0]) |-> ($past(en_out) == 3'b000) && (en_out == 3'b001));

    p_pg_from_full_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr_good) |-> ($past(en_out) == 3'b111));

    p_rail_fault_keeps_en_r7: assert property (@(posedge clk) disable iff (rst)
        ($fell(pwr_good) && en_out[0]) |-> (en_out == 3'b111));

    p_main_collapse_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(en_out[0]) |-> ((en_out == 3'b000) && !pwr_good));
endmodule

// File: tb/pwrseq_ctrl_tb.sv
module pwrseq_ctrl_tb;
    localparam int unsigned CPU = 2;
    localparam int unsigned LUS = 20;
    localparam int unsigned SUS = 3;
    localparam int L = CPU * LUS;   // 40 cycles (R11)
    localparam int S = CPU * SUS;   // 6 cycles  (R11)

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] rail_ok = 4'b0000;
    logic [2:0] en_out;
    logic       pwr_good;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    pwrseq_ctrl #(.CLK_PER_US(CPU), .LONG_US(LUS), .SHORT_US(SUS)) u_dut (
        .clk (clk), .rst (rst), .rail_ok (rail_ok), .en_out (en_out), .pwr_good (pwr_good)
    );

    always #2 clk = ~clk;   // 250 MHz

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic [3:0] exp, input string req);
        logic [3:0] got;
        got = {en_out[0], en_out[1], en_out[2], pwr_good};
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    initial begin
        step(3);
        rail_ok = 4'b1111;
        step(2);
        chk(4'b0000, "R1 outputs low in reset");
        rail_ok = 4'b0000;
        rst = 1'b0;
        step(L + 10);
        chk(4'b0000, "R1 off state with main rail low");

        // R9: main rail breaks just before the long hold completes
        rail_ok[0] = 1'b1;
        step(L - 3);
        rail_ok[0] = 1'b0;
        step(1);
        rail_ok[0] = 1'b1;
        step(L + 1);
        chk(4'b0000, "R9 restart after glitch / R3 not yet");
        step(1);
        chk(4'b1000, "R3 first enable after long hold (R11)");

        // R9: rail 1 high shorter than the short hold
        rail_ok[1] = 1'b1;
        step(S - 3);
        rail_ok[1] = 1'b0;
        step(S + 4);
        chk(4'b1000, "R9 short rail1 pulse ignored");
        rail_ok[1] = 1'b1;
        step(S + 1);
        chk(4'b1000, "R4 not before short hold");
        step(1);
        chk(4'b1100, "R4 second enable");

        rail_ok[2] = 1'b1;
        step(S + 1);
        chk(4'b1100, "R5 not before short hold");
        step(1);
        chk(4'b1110, "R5 third enable");

        // R9: main-rail low glitch in 1110
        rail_ok[0] = 1'b0;
        step(2);
        rail_ok[0] = 1'b1;
        step(S + 4);
        chk(4'b1110, "R9 main glitch ignored");

        rail_ok[3] = 1'b1;
        step(L + 1);
        chk(4'b1110, "R6 not before long hold");
        step(1);
        chk(4'b1111, "R6 power good");

        // R9: downstream glitch in power-good
        rail_ok[2] = 1'b0;
        step(2);
        rail_ok[2] = 1'b1;
        step(S + 4);
        chk(4'b1111, "R9 rail glitch ignored");

        // R7: downstream fault
        rail_ok[2] = 1'b0;
        step(S + 1);
        chk(4'b1111, "R7 not before short hold");
        step(1);
        chk(4'b1110, "R7 pg drops, enables kept");

        // R10: fresh long hold to re-enter power-good
        rail_ok[2] = 1'b1;
        step(S + 2);
        chk(4'b1110, "R10 no early re-entry");
        step(L + 1 - (S + 2));
        chk(4'b1110, "R10 full long hold still pending");
        step(1);
        chk(4'b1111, "R10 power good again");

        // R8: main fault from power-good
        rail_ok[0] = 1'b0;
        step(S + 1);
        chk(4'b1111, "R8 not before short hold");
        step(1);
        chk(4'b0000, "R8 main fault collapses all");

        // R10: bring-up with downstream rails already high
        rail_ok[0] = 1'b1;
        step(L + 2);
        chk(4'b1000, "R3 first enable on rebuild");
        step(S - 1);
        chk(4'b1000, "R10 step not early");
        step(1);
        chk(4'b1100, "R10 step one short hold after entry");
        step(S);
        chk(4'b1110, "R10 third enable one short hold after entry");
        step(L);
        chk(4'b1111, "R10 pg one long hold after entry");

        // R8: main fault from 1110 (via a downstream fault first)
        rail_ok[3] = 1'b0;
        step(S + 2);
        chk(4'b1110, "R7 rail3 fault");
        rail_ok[0] = 1'b0;
        step(S + 2);
        chk(4'b0000, "R8 main fault from 1110");

        // R8: main fault from 1100
        rail_ok = 4'b0011;
        step(L + 2);
        step(S);
        chk(4'b1100, "R4 rebuild to 1100");
        rail_ok[0] = 1'b0;
        step(S + 2);
        chk(4'b0000, "R8 main fault from 1100");

        finished = 1'b1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (100000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule